// File: doc/BRIEF.md
# Receive Descriptor Ring Write-Back Engine

This engine moves received frames from a MAC-side word stream into memory buffers that software posts on a circular ring of 32-byte (eight-word) descriptors. For each frame it reads the descriptor at its current ring position and checks that software has handed it over. It then reads the buffer pointer and writes the frame's bytes into that buffer, never past the posted size. At the end of the frame it writes back a status word and then a control word. The control word carries the stored length, the classification results and a set ownership bit, which returns the descriptor to software. A one-cycle receive-complete interrupt follows each hand-back.

Software programs the ring base and a poll-control register through a small write port. All memory traffic uses one request/acknowledge port with word addresses and byte enables. The input stream carries the frame's source port, protocol class, checksum flags and IP header offset as sideband with the last beat. When the current descriptor still belongs to software, the engine holds the stream off and polls the descriptor again until software releases it.

Top module: `rx_desc_writeback`

## Requirements
- R1: A memory request (`memReq`) stays asserted, with `memAddr`, `memWe` and write data unchanged, until the cycle in which `memAck` is high.
- R2: Before accepting a frame, the engine reads word offset 0 of the current descriptor. If bit 31 of that word is 1, the descriptor still belongs to software: `inReady` stays low, no interrupt is raised, and the word is re-read until bit 31 reads 0.
- R3: Frame beats are written to consecutive words starting at the word address held in descriptor word offset 2. Byte lane k (bits 8k+7..8k) of a beat holds frame byte 4*beat+k.
- R4: Byte enables are computed against the buffer size in bits 15:0 of descriptor word 0. No byte at a frame offset greater than or equal to that size is written. The stored length is the smaller of the frame length and the buffer size.
- R5: The hand-back write to word 0 contains the stored length in bits 15:0, the L4 checksum-fail flag in bit 16, the IP checksum-fail flag in bit 17, the protocol class in bits 21:18, zeros in bits 27:22, ones in bits 29:28, the end-of-ring flag read from the descriptor in bit 30, and 1 in bit 31.
- R6: The write to descriptor word offset 1 contains the source port in bits 10:8, the CRC-error flag in bit 11, the IP header offset in bits 21:17, and zeros in all other bits.
- R7: A register write with `regSel`=0 sets the poll control: bit 1 enables polling and bit 0 suspends it. A new descriptor fetch starts only when polling is enabled and not suspended.
- R8: `rxIrq` is high for exactly one cycle after each word-0 hand-back write, once per frame. The word-1 write is always the write that immediately precedes the hand-back write.
- R9: After a frame, the ring position advances by 8 words, or returns to the ring base when the descriptor's bit 30 was set. A register write with `regSel`=1 loads the ring base and moves the ring position to it.
- R10: On the last beat, `inLastBytes` gives the number of valid bytes (1, 2 or 3; 0 means 4). Every earlier beat carries 4 bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regSel | input | 1 | 0: poll control, 1: ring base |
| regWdata | input | 32 | Register write data |
| inValid | input | 1 | Stream beat valid |
| inReady | output | 1 | Stream beat accepted when high with inValid |
| inData | input | 32 | Stream beat, byte lane k is byte 4*beat+k |
| inLast | input | 1 | Last beat of the frame |
| inLastBytes | input | 2 | Valid bytes in the last beat (0 means 4) |
| inPort | input | 3 | Source port, valid with the last beat |
| inProto | input | 4 | Protocol class, valid with the last beat |
| inL4Fail | input | 1 | L4 checksum failed |
| inIpFail | input | 1 | IP checksum failed |
| inCrcErr | input | 1 | Frame CRC error |
| inIpOff | input | 5 | IP header offset |
| memReq | output | 1 | Memory request |
| memWe | output | 1 | 1 for write, 0 for read |
| memAddr | output | ADDR_W | Word address |
| memWdata | output | 32 | Write data |
| memBe | output | 4 | Byte enables for writes |
| memAck | input | 1 | Request accepted; read data is valid in this cycle |
| memRdata | input | 32 | Read data |
| rxIrq | output | 1 | Receive-complete pulse |

## Verification
The bench's memory model accepts each request after a random number of cycles and returns read data in the accepting cycle, so the exact cycle of every memory result varies. The checks therefore do not count fixed latencies. The interrupt is due one cycle after the acknowledged hand-back write; the bench counts it on falling edges and reads descriptor and buffer contents only after the expected count is reached. It then waits a few more cycles to confirm that no second pulse arrives. The hold-off and suspend checks watch `inReady` and `memReq` continuously over a window of tens of cycles. The ownership bit is released, or polling resumed, only after that window has closed.

// File: rtl/rxwb_pkg.sv
package rxwb_pkg;
  localparam int DESC_WORDS = 8;
  localparam int OFS_CTL    = 0;
  localparam int OFS_STAT   = 1;
  localparam int OFS_PTR    = 2;
  localparam int OWN_BIT    = 31;
  localparam int EOR_BIT    = 30;
  localparam int FSEG_BIT   = 29;
  localparam int LSEG_BIT   = 28;
  localparam int L4F_BIT    = 16;
  localparam int IPF_BIT    = 17;
  localparam int PROTO_LSB  = 18;
  localparam int PORT_LSB   = 8;
  localparam int CRC_BIT    = 11;
  localparam int IPOFF_LSB  = 17;

  typedef enum logic [2:0] {
    SEL_CTL, SEL_PTR, SEL_DATA, SEL_STAT, SEL_WB
  } memSel_e;

  typedef struct packed {
    logic    loadDesc;
    logic    loadPtr;
    logic    takeBeat;
    logic    advance;
    memSel_e sel;
  } ctlStrb_t;
endpackage

// File: rtl/rxwb_ctrl.sv
module rxwb_ctrl
  import rxwb_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     cfgWe,
  input  logic [1:0] cfgBits,
  input  logic     inValid,
  input  logic     inLast,
  input  logic     memAck,
  input  logic     ownBit,
  input  logic     beatWrites,
  output logic     inReady,
  output logic     memReq,
  output logic     memWe,
  output logic     rxIrq,
  output ctlStrb_t strb
);
  typedef enum logic [2:0] {
    ST_IDLE, ST_RD_CTL, ST_RD_PTR, ST_DATA, ST_WR_DATA, ST_WR_STAT, ST_WR_CTL
  } state_e;

  state_e state, nextState;
  logic pollEn, pollSusp, frameDone;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      pollEn    <= 1'b0;
      pollSusp  <= 1'b0;
      frameDone <= 1'b0;
      rxIrq     <= 1'b0;
    end else begin
      state <= nextState;
      if (cfgWe) begin
        pollEn   <= cfgBits[1];
        pollSusp <= cfgBits[0];
      end
      if (strb.loadDesc) frameDone <= 1'b0;
      else if (strb.takeBeat && inLast) frameDone <= 1'b1;
      rxIrq <= (state == ST_WR_CTL) && memAck;
    end
  end

  always_comb begin
    nextState = state;
    inReady   = 1'b0;
    memReq    = 1'b0;
    memWe     = 1'b0;
    strb      = '{loadDesc: 1'b0, loadPtr: 1'b0, takeBeat: 1'b0,
                  advance: 1'b0, sel: SEL_CTL};
    unique case (state)
      ST_IDLE: begin
        if (pollEn && !pollSusp && inValid) nextState = ST_RD_CTL;
      end
      ST_RD_CTL: begin
        memReq = 1'b1;
        if (memAck) begin
          if (!ownBit) begin
            strb.loadDesc = 1'b1;
            nextState     = ST_RD_PTR;
          end else begin
            nextState = ST_IDLE;
          end
        end
      end
      ST_RD_PTR: begin
        memReq   = 1'b1;
        strb.sel = SEL_PTR;
        if (memAck) begin
          strb.loadPtr = 1'b1;
          nextState    = ST_DATA;
        end
      end
      ST_DATA: begin
        inReady  = 1'b1;
        strb.sel = SEL_DATA;
        if (inValid) begin
          strb.takeBeat = 1'b1;
          if (beatWrites) nextState = ST_WR_DATA;
          else if (inLast) nextState = ST_WR_STAT;
        end
      end
      ST_WR_DATA: begin
        memReq   = 1'b1;
        memWe    = 1'b1;
        strb.sel = SEL_DATA;
        if (memAck) nextState = frameDone ? ST_WR_STAT : ST_DATA;
      end
      ST_WR_STAT: begin
        memReq   = 1'b1;
        memWe    = 1'b1;
        strb.sel = SEL_STAT;
        if (memAck) nextState = ST_WR_CTL;
      end
      ST_WR_CTL: begin
        memReq   = 1'b1;
        memWe    = 1'b1;
        strb.sel = SEL_WB;
        if (memAck) begin
          strb.advance = 1'b1;
          nextState    = ST_IDLE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/rxwb_datapath.sv
module rxwb_datapath
  import rxwb_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrb_t          strb,
  input  logic              baseWe,
  input  logic [31:0]       regWdata,
  input  logic [31:0]       inData,
  input  logic              inLast,
  input  logic [1:0]        inLastBytes,
  input  logic [2:0]        inPort,
  input  logic [3:0]        inProto,
  input  logic              inL4Fail,
  input  logic              inIpFail,
  input  logic              inCrcErr,
  input  logic [4:0]        inIpOff,
  input  logic [31:0]       memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [31:0]       memWdata,
  output logic [3:0]        memBe,
  output logic              beatWrites
);
  localparam int CNT_W = LEN_W + 1;

  logic [ADDR_W-1:0] ringBase, descAddr, bufPtr, wordIdx, dataAddr;
  logic [LEN_W-1:0]  bufSize, storedLen;
  logic [CNT_W-1:0]  byteCnt;
  logic              eorFlag;
  logic [31:0]       dataWord, ctlWord, statWord;
  logic [3:0]        dataBe, laneBe;
  logic [2:0]        beatBytes;
  logic [2:0]        sbPort;
  logic [3:0]        sbProto;
  logic              sbL4, sbIp, sbCrc;
  logic [4:0]        sbIpOff;
  logic              unusedBits;

  assign unusedBits = ^{memRdata, regWdata};
  assign beatBytes  = (inLast && inLastBytes != 2'd0) ? {1'b0, inLastBytes} : 3'd4;

  for (genvar k = 0; k < 4; k++) begin : g_lane
    assign laneBe[k] = ((byteCnt + CNT_W'(k)) < {1'b0, bufSize}) && (3'(k) < beatBytes);
  end
  assign beatWrites = |laneBe;

  assign storedLen = (byteCnt > {1'b0, bufSize}) ? bufSize : byteCnt[LEN_W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ringBase <= '0;
      descAddr <= '0;
      bufPtr   <= '0;
      wordIdx  <= '0;
      dataAddr <= '0;
      bufSize  <= '0;
      byteCnt  <= '0;
      eorFlag  <= 1'b0;
      dataWord <= '0;
      dataBe   <= '0;
      sbPort   <= '0;
      sbProto  <= '0;
      sbL4     <= 1'b0;
      sbIp     <= 1'b0;
      sbCrc    <= 1'b0;
      sbIpOff  <= '0;
    end else begin
      if (baseWe) begin
        ringBase <= regWdata[ADDR_W-1:0];
        descAddr <= regWdata[ADDR_W-1:0];
      end else if (strb.advance) begin
        descAddr <= eorFlag ? ringBase : descAddr + ADDR_W'(DESC_WORDS);
      end
      if (strb.loadDesc) begin
        bufSize <= memRdata[LEN_W-1:0];
        eorFlag <= memRdata[EOR_BIT];
        byteCnt <= '0;
        wordIdx <= '0;
      end
      if (strb.loadPtr) bufPtr <= memRdata[ADDR_W-1:0];
      if (strb.takeBeat) begin
        dataWord <= inData;
        dataBe   <= laneBe;
        dataAddr <= bufPtr + wordIdx;
        wordIdx  <= wordIdx + 1'b1;
        if (!byteCnt[CNT_W-1]) byteCnt <= byteCnt + CNT_W'(beatBytes);
        if (inLast) begin
          sbPort  <= inPort;
          sbProto <= inProto;
          sbL4    <= inL4Fail;
          sbIp    <= inIpFail;
          sbCrc   <= inCrcErr;
          sbIpOff <= inIpOff;
        end
      end
    end
  end

  always_comb begin
    ctlWord                        = '0;
    ctlWord[15:0]                  = 16'(storedLen);
    ctlWord[L4F_BIT]               = sbL4;
    ctlWord[IPF_BIT]               = sbIp;
    ctlWord[PROTO_LSB +: 4]        = sbProto;
    ctlWord[LSEG_BIT]              = 1'b1;
    ctlWord[FSEG_BIT]              = 1'b1;
    ctlWord[EOR_BIT]               = eorFlag;
    ctlWord[OWN_BIT]               = 1'b1;
    statWord                       = '0;
    statWord[PORT_LSB +: 3]        = sbPort;
    statWord[CRC_BIT]              = sbCrc;
    statWord[IPOFF_LSB +: 5]       = sbIpOff;
  end

  always_comb begin
    memBe    = 4'hF;
    memWdata = '0;
    unique case (strb.sel)
      SEL_CTL:  memAddr = descAddr + ADDR_W'(OFS_CTL);
      SEL_PTR:  memAddr = descAddr + ADDR_W'(OFS_PTR);
      SEL_DATA: begin
        memAddr  = dataAddr;
        memWdata = dataWord;
        memBe    = dataBe;
      end
      SEL_STAT: begin
        memAddr  = descAddr + ADDR_W'(OFS_STAT);
        memWdata = statWord;
      end
      SEL_WB: begin
        memAddr  = descAddr + ADDR_W'(OFS_CTL);
        memWdata = ctlWord;
      end
      default:  memAddr = descAddr;
    endcase
  end
endmodule

// File: rtl/rx_desc_writeback.sv
module rx_desc_writeback
  import rxwb_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic              regSel,
  input  logic [31:0]       regWdata,
  input  logic              inValid,
  output logic              inReady,
  input  logic [31:0]       inData,
  input  logic              inLast,
  input  logic [1:0]        inLastBytes,
  input  logic [2:0]        inPort,
  input  logic [3:0]        inProto,
  input  logic              inL4Fail,
  input  logic              inIpFail,
  input  logic              inCrcErr,
  input  logic [4:0]        inIpOff,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [31:0]       memWdata,
  output logic [3:0]        memBe,
  input  logic              memAck,
  input  logic [31:0]       memRdata,
  output logic              rxIrq
);
  ctlStrb_t strb;
  logic     beatWrites;

  rxwb_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .cfgWe      (regWe && !regSel),
    .cfgBits    (regWdata[1:0]),
    .inValid    (inValid),
    .inLast     (inLast),
    .memAck     (memAck),
    .ownBit     (memRdata[OWN_BIT]),
    .beatWrites (beatWrites),
    .inReady    (inReady),
    .memReq     (memReq),
    .memWe      (memWe),
    .rxIrq      (rxIrq),
    .strb       (strb)
  );

  rxwb_datapath #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .baseWe      (regWe && regSel),
    .regWdata    (regWdata),
    .inData      (inData),
    .inLast      (inLast),
    .inLastBytes (inLastBytes),
    .inPort      (inPort),
    .inProto     (inProto),
    .inL4Fail    (inL4Fail),
    .inIpFail    (inIpFail),
    .inCrcErr    (inCrcErr),
    .inIpOff     (inIpOff),
    .memRdata    (memRdata),
    .memAddr     (memAddr),
    .memWdata    (memWdata),
    .memBe       (memBe),
    .beatWrites  (beatWrites)
  );
endmodule

// File: rtl/rx_desc_writeback_chk.sv
module rx_desc_writeback_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWe,
  input logic              regSel,
  input logic [31:0]       regWdata,
  input logic              memReq,
  input logic              memWe,
  input logic              memAck,
  input logic [ADDR_W-1:0] memAddr,
  input logic [31:0]       memWdata,
  input logic              rxIrq
);
  logic activeChk;

  always_ff @(posedge clk) begin
    if (!rstN) activeChk <= 1'b0;
    else if (regWe && !regSel) activeChk <= regWdata[1] && !regWdata[0];
  end

  assert_req_held_R1: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> memReq && $stable(memAddr) && $stable(memWe));

  assert_wdata_held_R1: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memWe && !memAck |=> $stable(memWdata));

  assert_fetch_gated_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memReq) && !memWe |-> $past(activeChk));

  assert_irq_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    rxIrq |=> !rxIrq);

  assert_irq_after_handback_R8: assert property (@(posedge clk) disable iff (!rstN)
    rxIrq |-> $past(memReq && memWe && memAck && memWdata[31]));
endmodule

bind rx_desc_writeback rx_desc_writeback_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .regWe    (regWe),
  .regSel   (regSel),
  .regWdata (regWdata),
  .memReq   (memReq),
  .memWe    (memWe),
  .memAck   (memAck),
  .memAddr  (memAddr),
  .memWdata (memWdata),
  .rxIrq    (rxIrq)
);

// File: tb/rx_desc_writeback_test.sv
`timescale 1ns/1ps
module rx_desc_writeback_test;
  localparam int AW    = 12;
  localparam int RING0 = 'h100;
  localparam int RING1 = 'h180;
  localparam int BUF0  = 'h400;
  localparam int BUFW  = 128;
  localparam int NDESC = 4;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rstN = 1'b0;
  logic regWe = 1'b0, regSel = 1'b0;
  logic [31:0] regWdata = '0;
  logic inValid = 1'b0, inLast = 1'b0;
  logic inReady;
  logic [31:0] inData = '0;
  logic [1:0] inLastBytes = '0;
  logic [2:0] inPort = '0;
  logic [3:0] inProto = '0;
  logic inL4Fail = 1'b0, inIpFail = 1'b0, inCrcErr = 1'b0;
  logic [4:0] inIpOff = '0;
  logic memReq, memWe, rxIrq;
  logic [AW-1:0] memAddr;
  logic [31:0] memWdata;
  logic [3:0] memBe;
  logic memAck = 1'b0;
  logic [31:0] memRdata = '0;

  rx_desc_writeback #(.ADDR_W(AW)) uut (.*);

  logic [31:0] mem [0:(1<<AW)-1];
  logic [7:0]  fb [0:511];
  int checks = 0, fails = 0, irqCount = 0, irqExp = 0;
  int curBase = RING0, curIdx = 0;
  logic [AW-1:0] lastWr = '0, prevWr = '0;
  bit sawReq = 0, sawReady = 0, sendDone = 0;

  always @(negedge clk) begin
    memAck   <= memReq && ($urandom % 4 != 0);
    memRdata <= mem[memAddr];
    if (memReq)  sawReq = 1;
    if (inReady) sawReady = 1;
    if (rxIrq)   irqCount++;
  end

  always @(posedge clk) begin
    if (rstN && memReq && memWe && memAck) begin
      for (int k = 0; k < 4; k++)
        if (memBe[k]) mem[memAddr][8*k +: 8] <= memWdata[8*k +: 8];
      prevWr <= lastWr;
      lastWr <= memAddr;
    end
  end

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic regWrite(bit sel, logic [31:0] d);
    @(negedge clk);
    regWe = 1; regSel = sel; regWdata = d;
    @(negedge clk);
    regWe = 0;
  endtask

  task automatic postDesc(int idx, int size, bit own);
    int a = curBase + 8*idx;
    bit eor = (idx == NDESC-1);
    mem[a]   = {own, eor, 2'b11, 12'b0, 16'(size)};
    mem[a+1] = 32'hDEAD_BEEF;
    mem[a+2] = BUF0 + idx*BUFW;
    for (int w = 0; w < BUFW; w++) mem[BUF0 + idx*BUFW + w] = 32'hA5A5_A5A5;
  endtask

  task automatic randomFrame();
    for (int i = 0; i < 512; i++) fb[i] = 8'($urandom);
    inPort = 3'($urandom); inProto = 4'($urandom);
    inL4Fail = 1'($urandom); inIpFail = 1'($urandom);
    inCrcErr = 1'($urandom); inIpOff = 5'($urandom);
  endtask

  task automatic sendFrame(int len);
    int nb = (len + 3) / 4;
    sendDone = 0;
    @(negedge clk);
    for (int b = 0; b < nb; b++) begin
      inValid = 1;
      inData  = {fb[4*b+3], fb[4*b+2], fb[4*b+1], fb[4*b]};
      inLast  = (b == nb-1);
      inLastBytes = (b == nb-1) ? 2'(len % 4) : 2'd0;
      while (!inReady) @(negedge clk);
      @(negedge clk);
    end
    inValid = 0; inLast = 0;
    sendDone = 1;
  endtask

  task automatic waitIrq();
    int t = 0;
    irqExp++;
    while (irqCount < irqExp && t < 3000) begin @(negedge clk); t++; end
    check(irqCount >= irqExp, "R8 interrupt after frame", irqCount, irqExp);
    repeat (6) @(negedge clk);
    check(irqCount == irqExp, "R8 one pulse per frame", irqCount, irqExp);
  endtask

  task automatic checkFrame(int idx, int size, int len);
    int a = curBase + 8*idx;
    int stored = (len < size) ? len : size;
    int bad = 0;
    int bp = BUF0 + idx*BUFW;
    bit eor = (idx == NDESC-1);
    logic [31:0] e0 = {1'b1, eor, 2'b11, 6'b0, inProto, inIpFail, inL4Fail, 16'(stored)};
    logic [31:0] e1 = {10'b0, inIpOff, 5'b0, inCrcErr, inPort, 8'b0};
    check(mem[a] == e0, "R5 hand-back word (R4 stored length)", mem[a], e0);
    check(mem[a+1] == e1, "R6 status word", mem[a+1], e1);
    for (int i = 0; i < stored; i++)
      if (mem[bp + i/4][8*(i%4) +: 8] != fb[i]) bad++;
    check(bad == 0, "R3 R10 buffer bytes", bad, 0);
    if (stored < BUFW*4)
      check(mem[bp + stored/4][8*(stored%4) +: 8] == 8'hA5, "R4 byte past buffer untouched",
            mem[bp + stored/4], 32'hA5A5_A5A5);
    check(lastWr == AW'(a) && prevWr == AW'(a+1), "R8 status before hand-back",
          {lastWr, 4'h0, prevWr}, {AW'(a), 4'h0, AW'(a+1)});
  endtask

  task automatic doFrame(int len, int size);
    postDesc(curIdx, size, 0);
    randomFrame();
    sendFrame(len);
    waitIrq();
    checkFrame(curIdx, size, len);
    curIdx = (curIdx + 1) % NDESC;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < (1<<AW); i++) mem[i] = 32'h0;
    mem[RING0 + 8*NDESC] = 32'h5A5A_0F0F;
    repeat (4) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check(!memReq && !inReady && !rxIrq, "R1 reset state idle",
          {memReq, inReady, rxIrq}, 0);

    regWrite(1, RING0);
    // R7: polling disabled, no fetch
    postDesc(curIdx, 512, 0);
    randomFrame();
    sawReq = 0;
    fork sendFrame(12); join_none
    repeat (40) @(negedge clk);
    check(!sawReq, "R7 no fetch while disabled", sawReq, 0);
    regWrite(0, 32'h2);
    wait (sendDone);
    waitIrq();
    checkFrame(curIdx, 512, 12);
    curIdx++;

    // R10 directed lengths
    doFrame(1, 512);
    doFrame(2, 512);
    doFrame(3, 512);   // wraps (R9)
    doFrame(5, 512);
    // R4 truncation corners
    doFrame(17, 10);
    doFrame(8, 8);
    doFrame(8, 7);
    doFrame(64, 63);

    // random mix
    for (int n = 0; n < 12; n++) begin
      int len = 1 + $urandom % 120;
      int size = ($urandom % 3 == 0) ? 1 + $urandom % 64 : 512;
      doFrame(len, size);
    end

    // R2: descriptor still software's
    postDesc(curIdx, 64, 1);
    randomFrame();
    sawReady = 0;
    fork sendFrame(20); join_none
    repeat (60) @(negedge clk);
    check(!sawReady, "R2 stream held while not owned", sawReady, 0);
    check(irqCount == irqExp, "R2 no interrupt while not owned", irqCount, irqExp);
    mem[curBase + 8*curIdx][31] = 1'b0;
    wait (sendDone);
    waitIrq();
    checkFrame(curIdx, 64, 20);
    curIdx = (curIdx + 1) % NDESC;

    // R7: suspend
    regWrite(0, 32'h3);
    postDesc(curIdx, 512, 0);
    randomFrame();
    sawReq = 0;
    fork sendFrame(30); join_none
    repeat (40) @(negedge clk);
    check(!sawReq, "R7 no fetch while suspended", sawReq, 0);
    regWrite(0, 32'h2);
    wait (sendDone);
    waitIrq();
    checkFrame(curIdx, 512, 30);
    curIdx = (curIdx + 1) % NDESC;

    check(mem[RING0 + 8*NDESC] == 32'h5A5A_0F0F, "R9 nothing written past ring end",
          mem[RING0 + 8*NDESC], 32'h5A5A_0F0F);

    // R9: new ring base
    regWrite(1, RING1);
    curBase = RING1;
    curIdx = 0;
    doFrame(40, 512);
    doFrame(9, 512);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule